// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a watchdog timer. Software reaches it through a small register port in the bus clock domain. The counter itself runs in a separate count clock domain, and a clock mux outside the block selects that clock. Software sets a timeout exponent, turns the count clock on and enables the watchdog. From then on it must restart the counter on time. If it does not, the counter reaches the timeout and the block emits a one-cycle reset request toward the system reset logic.

A restart takes two writes to the clear register, issued back to back and carrying two fixed keys. A restart is accepted only while the status register reports that the previous restart has finished. Every signal that crosses between the two clock domains goes through two-flop synchronizers. For this reason the read-back of the clock-on and enable bits lags the write, and software polls these bits before taking the next step, for example before changing the clock source select. Only the basic (non-windowed) mode is supported.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the control register reads 0, the status done bit (bit 0 at address 2) reads 1, and `wdt_rst_req` stays low.
- R2: The control register is at address 0, and its clock-on bit is bit 1. When this bit is written, its read-back keeps the old value for at least two bus reads and then takes the new value.
- R3: The enable bit of the control register is bit 0. Its read-back keeps the old value for at least two bus reads after a write and then follows the written value.
- R4: The timeout exponent field is bits 8:4 of the control register. While the watchdog is enabled and the count clock is on, a reset request is issued 2^(P+1) count-clock cycles after the last restart (field value P), plus the synchronizer latency.
- R5: The reset request is high for exactly one bus clock cycle. After a timeout the counter saturates, so no further request follows until the counter is restarted.
- R6: The clear register is at address 1, with the key in bits 15:8 and the go bit in bit 0. A write with key 0x55 and go set, followed on the very next access by a write with key 0xAA and go set, restarts the counter. Repeating this sequence within the timeout prevents any reset request.
- R7: The done bit reads 0 on the first read after an accepted restart and returns to 1 no sooner than two reads later, once the count domain has applied the restart.
- R8: A restart sequence has no effect in any of these cases: the second write has the wrong key, the go bit is clear in either write, 0xAA comes without a preceding 0x55, or any other access (a read, or a write to another address) falls between the two writes. A sequence issued while done reads 0 is ignored.
- R9: A control write is ignored if its mode bit (bit 3) is 1. It is also ignored if it changes the clock source select (bit 2) while the clock-on bit is requested or reads back 1.
- R10: An accepted control write restarts the counter, so done reads 0 on the next read.
- R11: `cnt_clk_sel` follows the clock source select bit after an accepted control write, and the control read-back shows the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain synchronous reset, active low |
| cnt_clk | input | 1 | Count clock from the external clock mux |
| cnt_rst_n | input | 1 | Count-domain synchronous reset, active low |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 clear, 2 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| cnt_clk_sel | output | 1 | Clock source select for the external mux |
| wdt_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
A wrong internal state shows up at one of three places. A broken key tracker either leaves done high after a valid pair or drops it after an invalid one, and the next status read shows this. A stuck synchronizer or handshake leaves the clock-on, enable or done read-back frozen, and polling exposes it within a few dozen bus cycles. A counter that is not restarted, or that wraps, puts a reset request early, twice, or inside a window where periodic restarts should have kept it quiet. The pulse monitor catches this within one timeout period of 16 to 32 count cycles.

// File: rtl/wdt_pkg.sv
// Shared constants for the keyed-clear watchdog: register addresses,
// field positions and restart keys. Assumes an address width of 2 bits.
package wdt_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 2'd0,
        A_CLEAR = 2'd1,
        A_STAT  = 2'd2
    } wdt_addr_e;

    // control register fields
    localparam int CTL_EN       = 0;
    localparam int CTL_CLKON    = 1;
    localparam int CTL_SRC      = 2;
    localparam int CTL_MODE     = 3;
    localparam int CTL_PSEL_LSB = 4;

    // clear register fields
    localparam int CLR_GO      = 0;
    localparam int CLR_KEY_LSB = 8;
    localparam int KEY_W       = 8;
    localparam logic [KEY_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [KEY_W-1:0] KEY_SECOND = 8'hAA;

    // status register fields
    localparam int STAT_DONE = 0;
endpackage

// File: rtl/wdt_sync.sv
// Multi-stage flop synchronizer for WIDTH independent level signals.
// Assumes every bit is a slow level (held for several destination cycles).
module wdt_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first stage samples the foreign-domain level
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d;
            end
        end else begin : g_next
            // later stages settle a possibly metastable value
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wdt_key_seq.sv
// Detects the two-write restart sequence on the clear register.
// A first write with KEY_FIRST and go arms the tracker. The very next
// access must be a write with KEY_SECOND and go; any other access disarms.
// Fires only when the clear handshake reports done.
module wdt_key_seq
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access,
    input  logic             wr_clear,
    input  logic [KEY_W-1:0] key,
    input  logic             go,
    input  logic             done,
    output logic             armed,
    output logic             fire
);
    logic first_ok;

    assign first_ok = wr_clear && go && (key == KEY_FIRST);

    // track whether the last access was a valid first write
    always_ff @(posedge clk) begin
        if (!rst_n)      armed <= 1'b0;
        else if (access) armed <= first_ok;
    end

    assign fire = access && wr_clear && go && armed && done && (key == KEY_SECOND);
endmodule

// File: rtl/wdt_clr_hs.sv
// Bus-side four-phase handshake that holds the count-domain counter at
// zero. A launch while idle raises req at once. A launch while the count
// side is still releasing is kept pending. done is high only when idle.
// Assumes ack is the count side's synchronized copy of req, brought back.
module wdt_clr_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic ack,
    output logic req,
    output logic done
);
    logic pend;
    logic idle;
    logic start;

    assign idle  = !req && !ack;
    assign start = idle && (pend || launch);
    assign done  = idle && !pend;

    // raise req from idle, drop it once the count side acknowledges
    always_ff @(posedge clk) begin
        if (!rst_n)          req <= 1'b0;
        else if (start)      req <= 1'b1;
        else if (req && ack) req <= 1'b0;
    end

    // remember a launch that arrives while the release phase runs
    always_ff @(posedge clk) begin
        if (!rst_n)                     pend <= 1'b0;
        else if (start)                 pend <= 1'b0;
        else if (launch && !req && ack) pend <= 1'b1;
    end
endmodule

// File: rtl/wdt_counter.sv
// Count-domain timeout counter. It is cleared while hold is high or the
// watchdog is disabled, advances while the count clock is on, and
// saturates at 2^(psel+1). Assumes psel changes only while disabled or
// together with a hold from a control write.
module wdt_counter #(
    parameter int PSEL_W = 5
) (
    input  logic              cnt_clk,
    input  logic              cnt_rst_n,
    input  logic              hold,
    input  logic              enable,
    input  logic              clk_on,
    input  logic [PSEL_W-1:0] psel,
    output logic              expired
);
    localparam int CNT_W = (1 << PSEL_W) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(1) << (int'(psel) + 1);

    // next count: clear, advance, or hold at the limit
    always_comb begin
        if (hold || !enable)                 cnt_d = '0;
        else if (clk_on && (cnt_q != limit)) cnt_d = cnt_q + CNT_W'(1);
        else                                 cnt_d = cnt_q;
    end

    // count register and registered expiry flag (glitch-free for the sync)
    always_ff @(posedge cnt_clk) begin
        if (!cnt_rst_n) begin
            cnt_q   <= '0;
            expired <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            expired <= (cnt_d == limit);
        end
    end
endmodule

// File: rtl/wdt_keyed.sv
// Keyed-clear watchdog top: register port in the bus domain, counter in
// the count domain, two-flop synchronizers in both directions.
// Assumes single-cycle bus accesses and DATA_W >= 16.
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PSEL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_clk,
    input  logic              cnt_rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cnt_clk_sel,
    output logic              wdt_rst_req
);
    localparam int SYNC_STAGES = 2;
    localparam int TO_CNT_W    = 3;
    localparam int TO_BUS_W    = 4;

    // bus-domain control state
    logic              en_req;
    logic              clk_on_req;
    logic              src_q;
    logic [PSEL_W-1:0] psel_q;

    // read-backs and handshake
    logic en_rb, clk_on_rb, ack_b, expired_b, expired_d;
    logic hs_req, cleared, armed, key_fire;

    // count-domain copies
    logic en_c, clk_on_c, hold_c, expired_c;

    logic wr_ctrl, wr_clear, ctrl_ok, src_change_ok;
    logic unused_wdata;

    assign wr_ctrl  = bus_valid && bus_write && (bus_addr == A_CTRL);
    assign wr_clear = bus_valid && bus_write && (bus_addr == A_CLEAR);

    assign src_change_ok = (bus_wdata[CTL_SRC] == src_q) || (!clk_on_rb && !clk_on_req);
    assign ctrl_ok       = wr_ctrl && !bus_wdata[CTL_MODE] && src_change_ok;

    assign unused_wdata = ^{bus_wdata[DATA_W-1:CLR_KEY_LSB+KEY_W],
                            bus_wdata[CLR_KEY_LSB-1:CTL_PSEL_LSB+PSEL_W]};

    // accept a correct control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_req     <= 1'b0;
            clk_on_req <= 1'b0;
            src_q      <= 1'b0;
            psel_q     <= '0;
        end else if (ctrl_ok) begin
            en_req     <= bus_wdata[CTL_EN];
            clk_on_req <= bus_wdata[CTL_CLKON];
            src_q      <= bus_wdata[CTL_SRC];
            psel_q     <= bus_wdata[CTL_PSEL_LSB +: PSEL_W];
        end
    end

    assign cnt_clk_sel = src_q;

    wdt_key_seq u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .access   (bus_valid),
        .wr_clear (wr_clear),
        .key      (bus_wdata[CLR_KEY_LSB +: KEY_W]),
        .go       (bus_wdata[CLR_GO]),
        .done     (cleared),
        .armed    (armed),
        .fire     (key_fire)
    );

    wdt_clr_hs u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (key_fire || ctrl_ok),
        .ack    (ack_b),
        .req    (hs_req),
        .done   (cleared)
    );

    wdt_sync #(.WIDTH(TO_CNT_W), .STAGES(SYNC_STAGES)) u_sync_to_cnt (
        .clk   (cnt_clk),
        .rst_n (cnt_rst_n),
        .d     ({hs_req, clk_on_req, en_req}),
        .q     ({hold_c, clk_on_c, en_c})
    );

    wdt_counter #(.PSEL_W(PSEL_W)) u_cnt (
        .cnt_clk   (cnt_clk),
        .cnt_rst_n (cnt_rst_n),
        .hold      (hold_c),
        .enable    (en_c),
        .clk_on    (clk_on_c),
        .psel      (psel_q),
        .expired   (expired_c)
    );

    wdt_sync #(.WIDTH(TO_BUS_W), .STAGES(SYNC_STAGES)) u_sync_to_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({expired_c, hold_c, clk_on_c, en_c}),
        .q     ({expired_b, ack_b, clk_on_rb, en_rb})
    );

    // turn the expiry level into a single-cycle request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expired_d   <= 1'b0;
            wdt_rst_req <= 1'b0;
        end else begin
            expired_d   <= expired_b;
            wdt_rst_req <= expired_b && !expired_d;
        end
    end

    // register read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[CTL_EN]                     = en_rb;
            bus_rdata[CTL_CLKON]                  = clk_on_rb;
            bus_rdata[CTL_SRC]                    = src_q;
            bus_rdata[CTL_PSEL_LSB +: PSEL_W]     = psel_q;
        end else if (bus_addr == A_STAT) begin
            bus_rdata[STAT_DONE]                  = cleared;
        end
    end
endmodule

// File: rtl/wdt_keyed_chk.sv
// Assertion checker for wdt_keyed, attached by bind below.
module wdt_keyed_chk
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PSEL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_clk,
    input logic              cnt_rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              wdt_rst_req,
    input logic              clk_on_req,
    input logic              clk_on_rb,
    input logic              en_req,
    input logic              en_rb,
    input logic              src_q,
    input logic [PSEL_W-1:0] psel_q,
    input logic              armed,
    input logic              cleared,
    input logic              ctrl_ok,
    input logic              expired_c,
    input logic              hold_c,
    input logic              en_c
);
    // R5: request is one cycle wide
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !wdt_rst_req);

    // R5: expired counter holds, it does not wrap
    p_saturate_r5: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
        (expired_c && !hold_c && en_c) |=> expired_c);

    // R2: clock-on read-back lags its request
    p_clkon_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_on_rb) |-> ($past(clk_on_req) && $past(clk_on_req, 2)));

    // R3: enable read-back lags its request
    p_en_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_rb) |-> ($past(en_req) && $past(en_req, 2)));

    // R9: a mode-1 control write changes nothing
    p_mode_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && (bus_addr == A_CTRL) && bus_wdata[CTL_MODE])
        |=> ($stable(en_req) && $stable(clk_on_req) && $stable(src_q) && $stable(psel_q)));

    // R7: an accepted key pair drops done
    p_clear_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && (bus_addr == A_CLEAR) && bus_wdata[CLR_GO]
         && (bus_wdata[CLR_KEY_LSB +: KEY_W] == KEY_SECOND) && armed && cleared)
        |=> !cleared);

    // R10: an accepted control write drops done
    p_ctrl_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_ok && cleared) |=> !cleared);
endmodule

bind wdt_keyed wdt_keyed_chk #(.DATA_W(DATA_W), .PSEL_W(PSEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_clk     (cnt_clk),
    .cnt_rst_n   (cnt_rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .wdt_rst_req (wdt_rst_req),
    .clk_on_req  (clk_on_req),
    .clk_on_rb   (clk_on_rb),
    .en_req      (en_req),
    .en_rb       (en_rb),
    .src_q       (src_q),
    .psel_q      (psel_q),
    .armed       (armed),
    .cleared     (cleared),
    .ctrl_ok     (ctrl_ok),
    .expired_c   (expired_c),
    .hold_c      (hold_c),
    .en_c        (en_c)
);

// File: tb/wdt_keyed_tb_top.sv
// Directed bench for wdt_keyed: one task per scenario.
module wdt_keyed_tb_top;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              cnt_clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cnt_rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [1:0]        bus_addr = 2'd0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              cnt_clk_sel;
    logic              wdt_rst_req;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int cc = 0;
    int pulses = 0;
    int run_len = 0;
    int max_len = 0;
    int last_pulse_cc = 0;

    always #2 clk = ~clk;
    always #5 cnt_clk = ~cnt_clk;

    wdt_keyed #(.DATA_W(DATA_W), .PSEL_W(5)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_clk     (cnt_clk),
        .cnt_rst_n   (cnt_rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cnt_clk_sel (cnt_clk_sel),
        .wdt_rst_req (wdt_rst_req)
    );

    always @(posedge cnt_clk) cc++;

    // pulse monitor, sampled away from the bus clock edge
    always @(negedge clk) begin
        if (wdt_rst_req) begin
            pulses++;
            run_len++;
            if (run_len > max_len) max_len = run_len;
            last_pulse_cc = cc;
        end else begin
            run_len = 0;
        end
    end

    function automatic logic [DATA_W-1:0] ctl(bit en, bit on, bit src, bit mode, int psel);
        return DATA_W'((psel << 4) | (int'(mode) << 3) | (int'(src) << 2) | (int'(on) << 1) | int'(en));
    endfunction

    function automatic logic [DATA_W-1:0] clr(int key, bit go);
        return DATA_W'((key << 8) | int'(go));
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic bus_wr(logic [1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_rd(logic [1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // read until bit idx equals val; n = reads that still showed the old value
    task automatic poll(logic [1:0] a, int idx, bit val, output int n);
        logic [DATA_W-1:0] d;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            bus_rd(a, d);
            if (d[idx] == val) return;
            n++;
        end
    endtask

    task automatic wait_pulse(int base, int max_cyc);
        for (int i = 0; i < max_cyc; i++) begin
            if (pulses > base) return;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] d;
        bus_rd(2'd0, d); check(d == 0, "R1 ctrl", d, 0);
        bus_rd(2'd2, d); check(d == 1, "R1 status", d, 1);
        check(pulses == 0, "R1 no request", pulses, 0);
    endtask

    task automatic t_clock_on();
        int n;
        bus_wr(2'd0, ctl(0, 1, 0, 0, 0));
        poll(2'd0, 1, 1'b1, n);
        check(n >= 2 && n < 200, "R2 on lag", n, 2);
        bus_wr(2'd0, ctl(0, 0, 0, 0, 0));
        poll(2'd0, 1, 1'b0, n);
        check(n >= 2 && n < 200, "R2 off lag", n, 2);
    endtask

    task automatic t_source();
        logic [DATA_W-1:0] d;
        int n;
        bus_wr(2'd0, ctl(0, 0, 1, 0, 0));
        check(cnt_clk_sel == 1'b1, "R11 sel out", cnt_clk_sel, 1);
        bus_rd(2'd0, d); check(d[2] == 1'b1, "R11 sel readback", d[2], 1);
        bus_wr(2'd0, ctl(0, 1, 1, 0, 0));
        poll(2'd0, 1, 1'b1, n);
        bus_wr(2'd0, ctl(0, 1, 0, 0, 0));
        check(cnt_clk_sel == 1'b1, "R9 src locked", cnt_clk_sel, 1);
        bus_wr(2'd0, ctl(1, 1, 1, 1, 7));
        bus_rd(2'd0, d); check(d == 32'h6, "R9 mode ignored", d, 6);
    endtask

    task automatic t_enable();
        logic [DATA_W-1:0] d;
        int n;
        bus_wr(2'd0, ctl(1, 1, 1, 0, 20));
        poll(2'd0, 0, 1'b1, n);
        check(n >= 2 && n < 200, "R3 enable lag", n, 2);
        bus_rd(2'd0, d); check(d[8:4] == 20, "R4 psel field", d[8:4], 20);
    endtask

    task automatic t_ctrl_restart();
        logic [DATA_W-1:0] d;
        int n;
        bus_wr(2'd0, ctl(1, 1, 1, 0, 20));
        bus_rd(2'd2, d); check(d[0] == 1'b0, "R10 done drops", d[0], 0);
        poll(2'd2, 0, 1'b1, n);
        check(n >= 1 && n < 200, "R7 done returns", n, 1);
    endtask

    task automatic t_timeout();
        int n, base, c0;
        bus_wr(2'd0, ctl(0, 1, 1, 0, 3));
        poll(2'd0, 0, 1'b0, n);
        poll(2'd2, 0, 1'b1, n);
        base = pulses; max_len = 0;
        c0 = cc;
        bus_wr(2'd0, ctl(1, 1, 1, 0, 3));
        wait_pulse(base, 600);
        check(pulses == base + 1, "R4 request seen", pulses - base, 1);
        check(last_pulse_cc - c0 >= 16 && last_pulse_cc - c0 <= 40,
              "R4 timeout cycles", last_pulse_cc - c0, 16);
        check(max_len == 1, "R5 one cycle", max_len, 1);
        repeat (300) @(negedge clk);
        check(pulses == base + 1, "R5 no wrap", pulses - base, 1);
    endtask

    task automatic t_keep_alive();
        logic [DATA_W-1:0] d;
        int n, base, bad;
        bus_wr(2'd0, ctl(0, 1, 1, 0, 3));
        poll(2'd0, 0, 1'b0, n);
        bus_wr(2'd0, ctl(1, 1, 1, 0, 4));
        poll(2'd0, 0, 1'b1, n);
        base = pulses; bad = 0;
        for (int i = 0; i < 12; i++) begin
            repeat (30) @(negedge clk);
            poll(2'd2, 0, 1'b1, n);
            bus_wr(2'd1, clr(8'h55, 1));
            bus_wr(2'd1, clr(8'hAA, 1));
            bus_rd(2'd2, d);
            if (d[0] != 1'b0) bad++;
        end
        check(bad == 0, "R7 done drops per clear", bad, 0);
        check(pulses == base, "R6 no request", pulses - base, 0);
        wait_pulse(base, 600);
        check(pulses == base + 1, "R4 request after clears stop", pulses - base, 1);
    endtask

    task automatic t_bad_seq();
        logic [DATA_W-1:0] d;
        bus_wr(2'd1, clr(8'hAA, 1));
        bus_rd(2'd2, d); check(d[0] == 1'b1, "R8 lone second key", d[0], 1);
        bus_wr(2'd1, clr(8'h55, 1));
        bus_rd(2'd2, d);
        bus_wr(2'd1, clr(8'hAA, 1));
        bus_rd(2'd2, d); check(d[0] == 1'b1, "R8 read between", d[0], 1);
        bus_wr(2'd1, clr(8'h55, 1));
        bus_wr(2'd2, 32'h0);
        bus_wr(2'd1, clr(8'hAA, 1));
        bus_rd(2'd2, d); check(d[0] == 1'b1, "R8 write between", d[0], 1);
        bus_wr(2'd1, clr(8'h55, 0));
        bus_wr(2'd1, clr(8'hAA, 1));
        bus_rd(2'd2, d); check(d[0] == 1'b1, "R8 first go clear", d[0], 1);
        bus_wr(2'd1, clr(8'h55, 1));
        bus_wr(2'd1, clr(8'hAA, 0));
        bus_rd(2'd2, d); check(d[0] == 1'b1, "R8 second go clear", d[0], 1);
        bus_wr(2'd1, clr(8'h55, 1));
        bus_wr(2'd1, clr(8'h5A, 1));
        bus_rd(2'd2, d); check(d[0] == 1'b1, "R8 wrong key", d[0], 1);
        bus_wr(2'd1, clr(8'h55, 1));
        bus_wr(2'd1, clr(8'hAA, 1));
        bus_rd(2'd2, d); check(d[0] == 1'b0, "R6 valid pair", d[0], 0);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        cnt_rst_n = 1'b1;
        t_reset();
        t_clock_on();
        t_source();
        t_enable();
        t_ctrl_restart();
        t_timeout();
        t_keep_alive();
        t_bad_seq();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule